// File: doc/BRIEF.md
# Accumulator-Style Minicomputer Core with Indirect Bit and Skip Flow

This block is a small word-oriented processor core in the manner of early minicomputers. It has four general registers and an 11-bit program counter, and it talks to a single synchronous memory port. Every memory-reference instruction carries one indirect bit. When that bit is set, the core first reads the word at the address field and uses the low bits of that word as the effective address. This costs exactly one extra memory cycle and resolves a single level only.

The core has no compare-and-branch instructions. Conditional flow uses skips that step over the following instruction. There is a zero test and a sign test on a register, and on these two instructions the indirect bit inverts the test instead of acting on an address. An increment-and-skip-if-zero instruction on a memory word works as the loop counter, and an unconditional jump closes the loop. A barrel shifter moves a register by up to nine positions in one instruction, as a logical shift or a rotate, in either direction.

Memory reads are synchronous: data requested in one cycle appears on the read-data input in the next cycle. The core reports through two outputs: a halted flag and its current program counter.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `halted_o` is 0 and `pc_o` is 0. In that first cycle the core requests a read at address 0. All four registers start at 0.
- R2: An instruction word has its opcode in bits [17:14], the register select in [13:12], the indirect bit in [11] and the address field in [10:0]. The opcodes are 0 halt, 1 load, 2 store, 3 add, 4 jump, 5 skip-if-zero, 6 skip-if-negative, 7 increment-and-skip, 8 shift. Every other opcode is a no-op that advances the program counter by 1.
- R3: Load copies M[ea] into the selected register. Store writes the register to M[ea]. Add sets the register to the register plus M[ea], wrapping modulo 2^18.
- R4: With the indirect bit set on a memory-reference instruction, the effective address is bits [10:0] of the word at the address field. This is one level only, and it takes exactly one cycle more than the direct form.
- R5: Skip-if-zero advances the program counter by 2 when the selected register is 0, and skip-if-negative does so when its bit 17 is 1. Otherwise either instruction advances it by 1. The indirect bit inverts the test and causes no memory access.
- R6: Increment-and-skip writes M[ea]+1 (modulo 2^18) back to M[ea]. It advances the program counter by 2 when that result is 0 and by 1 otherwise.
- R7: Shift takes its count from address bits [3:0], with counts above 9 treated as 9. Bit [4]=1 selects rotate and 0 selects logical shift with zero fill. Bit [5]=1 selects right and 0 selects left.
- R8: Halt stops the core. `halted_o` stays 1, `pc_o` holds the address of the halt word, and no memory read or write is issued afterwards.
- R9: A read and a write are never requested in the same cycle.
- R10: Jump loads the program counter with the effective address, and it honours the indirect bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr_o | output | 11 | Memory address for a read or write |
| mem_rd_o | output | 1 | Read request, data returned next cycle |
| mem_wr_o | output | 1 | Write request |
| mem_wdata_o | output | 18 | Write data |
| mem_rdata_i | input | 18 | Read data for the previous cycle's request |
| halted_o | output | 1 | Core has executed a halt |
| pc_o | output | 11 | Current program counter |

## Verification
Several properties are checked on every cycle. The memory port never reads and writes together, the halted state is sticky and quiet on the bus, an indirect-resolution cycle always follows a read, and writes only come from the store and write-back states. The shifter checks that a zero count passes data through. Only the bench scenarios show the arithmetic results, the skip and inverted-skip outcomes, the single-level indirection with its one-cycle cost, the counted loop built from increment-and-skip, and the clamped shift and rotate values, because each of these depends on memory contents that the bench reads back after the program halts.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_JMP   = 4'd4,
        OP_SKZ   = 4'd5,
        OP_SKN   = 4'd6,
        OP_ISZ   = 4'd7,
        OP_SHF   = 4'd8
    } op_e;

    typedef enum logic [2:0] {
        S_FETCH  = 3'd0,
        S_DECODE = 3'd1,
        S_INDIR  = 3'd2,
        S_OPER   = 3'd3,
        S_WB     = 3'd4,
        S_HALT   = 3'd5
    } state_e;

endpackage

// File: rtl/acc_cpu_shifter.sv
module acc_cpu_shifter #(
    parameter int WORD_W    = 18,
    parameter int SHCNT_W   = 4,
    parameter int MAX_SHIFT = 9
) (
    input  logic [WORD_W-1:0]  din,
    input  logic [SHCNT_W-1:0] cnt,
    input  logic               rotate,
    input  logic               right,
    output logic [WORD_W-1:0]  dout
);

    localparam logic [SHCNT_W-1:0] CNT_MAX = SHCNT_W'(MAX_SHIFT);

    logic [SHCNT_W-1:0] amt;

    always_comb begin
        amt = (cnt > CNT_MAX) ? CNT_MAX : cnt;
    end

    always_comb begin
        dout = din;
        for (int k = 1; k <= MAX_SHIFT; k++) begin
            if (amt == SHCNT_W'(k)) begin
                case ({rotate, right})
                    2'b00:   dout = din << k;
                    2'b01:   dout = din >> k;
                    2'b10:   dout = (din << k) | (din >> (WORD_W - k));
                    default: dout = (din >> k) | (din << (WORD_W - k));
                endcase
            end
        end
    end

    // R7
    always_comb begin
        if (cnt == '0) begin
            zero_shift_chk: assert (dout == din);
        end
    end

endmodule

// File: rtl/acc_cpu_skip_eval.sv
module acc_cpu_skip_eval #(
    parameter int WORD_W = 18
) (
    input  logic [WORD_W-1:0] operand,
    input  logic              test_neg,
    input  logic              invert,
    output logic              skip
);

    logic cond;

    always_comb begin
        cond = test_neg ? operand[WORD_W-1] : (operand == '0);
        skip = cond ^ invert;
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int NREG      = 4,
    parameter int SHCNT_W   = 4,
    parameter int MAX_SHIFT = 9
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    output logic [ADDR_W-1:0]                       mem_addr_o,
    output logic                                    mem_rd_o,
    output logic                                    mem_wr_o,
    output logic [OPC_W+$clog2(NREG)+ADDR_W:0]      mem_wdata_o,
    input  logic [OPC_W+$clog2(NREG)+ADDR_W:0]      mem_rdata_i,
    output logic                                    halted_o,
    output logic [ADDR_W-1:0]                       pc_o
);

    localparam int RSEL_W = $clog2(NREG);
    localparam int WORD_W = OPC_W + RSEL_W + 1 + ADDR_W;
    localparam int IBIT   = ADDR_W;
    localparam int RSEL_LO = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PC_TWO = ADDR_W'(2);

    typedef struct packed {
        state_e                        st;
        logic [ADDR_W-1:0]             pc;
        logic [WORD_W-1:0]             ir;
        logic [ADDR_W-1:0]             ea;
        logic [NREG-1:0][WORD_W-1:0]   regs;
    } core_t;

    core_t core_d, core_q;

    logic [WORD_W-1:0] cur_ir;
    op_e               op;
    logic [RSEL_W-1:0] rsel;
    logic              ibit;
    logic [ADDR_W-1:0] field;
    logic [WORD_W-1:0] sel_reg;
    logic [WORD_W-1:0] shift_out;
    logic              skip;
    logic [WORD_W-1:0] inc_val;

    always_comb begin
        cur_ir  = (core_q.st == S_DECODE) ? mem_rdata_i : core_q.ir;
        op      = op_e'(cur_ir[WORD_W-1 -: OPC_W]);
        rsel    = cur_ir[RSEL_LO +: RSEL_W];
        ibit    = cur_ir[IBIT];
        field   = cur_ir[ADDR_W-1:0];
        sel_reg = core_q.regs[rsel];
        inc_val = mem_rdata_i + WORD_W'(1);
    end

    acc_cpu_shifter #(
        .WORD_W   (WORD_W),
        .SHCNT_W  (SHCNT_W),
        .MAX_SHIFT(MAX_SHIFT)
    ) u_shifter (
        .din   (sel_reg),
        .cnt   (field[SHCNT_W-1:0]),
        .rotate(field[SHCNT_W]),
        .right (field[SHCNT_W+1]),
        .dout  (shift_out)
    );

    acc_cpu_skip_eval #(
        .WORD_W(WORD_W)
    ) u_skip (
        .operand (sel_reg),
        .test_neg(op == OP_SKN),
        .invert  (ibit),
        .skip    (skip)
    );

    always_comb begin
        core_d      = core_q;
        mem_addr_o  = core_q.pc;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_wdata_o = sel_reg;

        case (core_q.st)
            S_FETCH: begin
                mem_rd_o  = 1'b1;
                core_d.st = S_DECODE;
            end
            S_DECODE: begin
                core_d.ir = mem_rdata_i;
                case (op)
                    OP_HALT: core_d.st = S_HALT;
                    OP_SKZ, OP_SKN: begin
                        core_d.pc = core_q.pc + (skip ? PC_TWO : PC_ONE);
                        core_d.st = S_FETCH;
                    end
                    OP_SHF: begin
                        core_d.regs[rsel] = shift_out;
                        core_d.pc         = core_q.pc + PC_ONE;
                        core_d.st         = S_FETCH;
                    end
                    OP_LOAD, OP_STORE, OP_ADD, OP_JMP, OP_ISZ: begin
                        if (ibit) begin
                            mem_rd_o   = 1'b1;
                            mem_addr_o = field;
                            core_d.st  = S_INDIR;
                        end else begin
                            core_d.ea = field;
                            core_d.st = S_OPER;
                        end
                    end
                    default: begin
                        core_d.pc = core_q.pc + PC_ONE;
                        core_d.st = S_FETCH;
                    end
                endcase
            end
            S_INDIR: begin
                core_d.ea = mem_rdata_i[ADDR_W-1:0];
                core_d.st = S_OPER;
            end
            S_OPER: begin
                case (op)
                    OP_STORE: begin
                        mem_wr_o   = 1'b1;
                        mem_addr_o = core_q.ea;
                        core_d.pc  = core_q.pc + PC_ONE;
                        core_d.st  = S_FETCH;
                    end
                    OP_JMP: begin
                        core_d.pc = core_q.ea;
                        core_d.st = S_FETCH;
                    end
                    default: begin
                        mem_rd_o   = 1'b1;
                        mem_addr_o = core_q.ea;
                        core_d.st  = S_WB;
                    end
                endcase
            end
            S_WB: begin
                core_d.st = S_FETCH;
                case (op)
                    OP_ISZ: begin
                        mem_wr_o    = 1'b1;
                        mem_addr_o  = core_q.ea;
                        mem_wdata_o = inc_val;
                        core_d.pc   = core_q.pc + ((inc_val == '0) ? PC_TWO : PC_ONE);
                    end
                    OP_ADD: begin
                        core_d.regs[rsel] = sel_reg + mem_rdata_i;
                        core_d.pc         = core_q.pc + PC_ONE;
                    end
                    default: begin
                        core_d.regs[rsel] = mem_rdata_i;
                        core_d.pc         = core_q.pc + PC_ONE;
                    end
                endcase
            end
            default: begin
                core_d.st = S_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q.st   <= S_FETCH;
            core_q.pc   <= '0;
            core_q.ir   <= '0;
            core_q.ea   <= '0;
            core_q.regs <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign halted_o = (core_q.st == S_HALT);
    assign pc_o     = core_q.pc;

    // R9
    no_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (halted_o && $stable(pc_o)));

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (!mem_rd_o && !mem_wr_o));

    // R4
    indir_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st == S_INDIR) |-> $past(mem_rd_o));

    // R3
    write_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (core_q.st == S_OPER || core_q.st == S_WB));

endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;

    localparam int AW = 11;
    localparam int DW = 18;
    localparam int RUN_LIMIT = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic          mem_rd_o, mem_wr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          halted_o;
    logic [AW-1:0] pc_o;

    logic [DW-1:0] mem [0:(1<<AW)-1];

    int checks = 0;
    int failures = 0;
    int rdwr_viol = 0;

    always #2 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk(clk), .rst_n(rst_n),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .halted_o(halted_o), .pc_o(pc_o)
    );

    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
        if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
    end

    always @(negedge clk) begin
        if (rst_n && mem_rd_o && mem_wr_o) rdwr_viol++;
    end

    function automatic logic [DW-1:0] enc(int op, int r, int i, int a);
        return {4'(op), 2'(r), 1'(i), 11'(a)};
    endfunction

    function automatic logic [DW-1:0] ref_shift(logic [DW-1:0] v, int n, bit rot, bit right);
        int c = (n > 9) ? 9 : n;
        logic [DW-1:0] x = v;
        for (int s = 0; s < c; s++) begin
            if (right) x = {rot ? x[0] : 1'b0, x[DW-1:1]};
            else       x = {x[DW-2:0], rot ? x[DW-1] : 1'b0};
        end
        return x;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int a = 0; a < (1 << AW); a++) mem[a] = '0;
    endtask

    task automatic run_prog(output int cyc);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!halted_o && cyc < RUN_LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        chk(halted_o == 1'b1, "R8 program reached halt", 32'(halted_o), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(halted_o == 1'b0, "R1 halted in reset", 32'(halted_o), 0);
        chk(pc_o == '0, "R1 pc in reset", 32'(pc_o), 0);
        rst_n = 1'b1;
        #1;
        chk(mem_rd_o == 1'b1 && mem_addr_o == '0, "R1 first fetch at 0",
            {mem_rd_o, 20'd0, mem_addr_o}, 32'h8000_0000);
        chk(halted_o == 1'b0 && pc_o == '0, "R1 state after release", 32'(pc_o), 0);
    endtask

    task automatic t_arith();
        int cyc;
        clear_mem();
        mem[100] = 18'h01234; mem[101] = 18'h00F0F;
        mem[102] = 18'h3FFFF; mem[103] = 18'h00002;
        mem[0] = enc(1, 1, 0, 100);
        mem[1] = enc(3, 1, 0, 101);
        mem[2] = enc(2, 1, 0, 200);
        mem[3] = enc(1, 2, 0, 102);
        mem[4] = enc(3, 2, 0, 103);
        mem[5] = enc(2, 2, 0, 201);
        mem[6] = enc(2, 3, 0, 202);
        mem[7] = enc(0, 0, 0, 0);
        run_prog(cyc);
        chk(mem[200] == 18'h02143, "R3 load add store", 32'(mem[200]), 32'h02143);
        chk(mem[201] == 18'h00001, "R3 add wraps", 32'(mem[201]), 1);
        chk(mem[202] == 18'h0, "R1 register reset to zero", 32'(mem[202]), 0);
    endtask

    task automatic t_indirect();
        int ca, cb;
        clear_mem();
        mem[110] = 18'd120; mem[120] = 18'd5; mem[5] = 18'h2AAAA;
        mem[111] = 18'd130;
        mem[0] = enc(1, 0, 1, 110);
        mem[1] = enc(2, 0, 1, 111);
        mem[2] = enc(4, 0, 1, 112);
        mem[112] = 18'd7;
        mem[3] = enc(2, 0, 0, 140);
        mem[7] = enc(0, 0, 0, 0);
        run_prog(cb);
        chk(mem[130] == 18'd5, "R4 single-level indirect load/store", 32'(mem[130]), 5);
        chk(mem[110] == 18'd120, "R4 pointer unchanged", 32'(mem[110]), 120);
        chk(mem[140] == 18'd0 && pc_o == 11'd7, "R10 indirect jump target",
            32'(pc_o), 7);

        clear_mem();
        mem[120] = 18'h00055;
        mem[0] = enc(1, 0, 0, 120);
        mem[1] = enc(0, 0, 0, 0);
        run_prog(ca);
        clear_mem();
        mem[110] = 18'd120; mem[120] = 18'h00055;
        mem[0] = enc(1, 0, 1, 110);
        mem[1] = enc(0, 0, 0, 0);
        run_prog(cb);
        chk(cb - ca == 1, "R4 indirect costs one cycle", 32'(cb - ca), 1);
    endtask

    task automatic t_skips();
        int cyc;
        clear_mem();
        mem[50] = 18'd7; mem[51] = 18'd0; mem[52] = 18'h20000;
        mem[0]  = enc(1, 1, 0, 50);
        mem[1]  = enc(1, 0, 0, 51);
        mem[2]  = enc(5, 0, 0, 0);
        mem[3]  = enc(2, 1, 0, 301);
        mem[4]  = enc(5, 0, 1, 51);
        mem[5]  = enc(2, 1, 0, 302);
        mem[6]  = enc(1, 0, 0, 52);
        mem[7]  = enc(6, 0, 0, 0);
        mem[8]  = enc(2, 1, 0, 303);
        mem[9]  = enc(6, 0, 1, 0);
        mem[10] = enc(2, 1, 0, 304);
        mem[11] = enc(5, 0, 0, 0);
        mem[12] = enc(2, 1, 0, 305);
        mem[13] = enc(15, 0, 0, 0);
        mem[14] = enc(2, 1, 0, 306);
        mem[15] = enc(0, 0, 0, 0);
        run_prog(cyc);
        chk(mem[301] == 0, "R5 zero skip taken", 32'(mem[301]), 0);
        chk(mem[302] == 7, "R5 inverted zero skip not taken", 32'(mem[302]), 7);
        chk(mem[303] == 0, "R5 negative skip taken", 32'(mem[303]), 0);
        chk(mem[304] == 7, "R5 inverted negative skip not taken", 32'(mem[304]), 7);
        chk(mem[305] == 7, "R5 zero skip on nonzero not taken", 32'(mem[305]), 7);
        chk(mem[306] == 7, "R2 unused opcode is no-op", 32'(mem[306]), 7);
        chk(mem[51] == 0 && mem[50] == 7, "R5 skip memory untouched", 32'(mem[51]), 0);
    endtask

    task automatic t_isz();
        int cyc;
        clear_mem();
        mem[60] = 18'h3FFFD; mem[61] = 18'd1; mem[62] = 18'd63; mem[63] = 18'd5;
        mem[0] = enc(7, 0, 1, 62);
        mem[1] = enc(3, 0, 0, 61);
        mem[2] = enc(7, 0, 0, 60);
        mem[3] = enc(4, 0, 0, 1);
        mem[4] = enc(2, 0, 0, 310);
        mem[5] = enc(0, 0, 0, 0);
        run_prog(cyc);
        chk(mem[63] == 18'd6, "R6 indirect increment", 32'(mem[63]), 6);
        chk(mem[62] == 18'd63, "R6 pointer kept", 32'(mem[62]), 63);
        chk(mem[310] == 18'd3, "R6 R10 loop count", 32'(mem[310]), 3);
        chk(mem[60] == 18'd0, "R6 counter wrapped to zero", 32'(mem[60]), 0);
    endtask

    task automatic t_shift();
        int cyc;
        int cnts [6] = '{4, 15, 2, 12, 0, 9};
        bit rots [6] = '{0, 1, 1, 0, 1, 1};
        bit rts  [6] = '{0, 0, 1, 1, 0, 1};
        logic [DW-1:0] v = 18'h20001;
        clear_mem();
        mem[70] = v;
        for (int i = 0; i < 6; i++) begin
            mem[3*i]   = enc(1, 3, 0, 70);
            mem[3*i+1] = enc(8, 3, 0, (int'(rts[i]) << 5) | (int'(rots[i]) << 4) | cnts[i]);
            mem[3*i+2] = enc(2, 3, 0, 330 + i);
        end
        mem[18] = enc(0, 0, 0, 0);
        run_prog(cyc);
        for (int i = 0; i < 6; i++) begin
            logic [DW-1:0] e = ref_shift(v, cnts[i], rots[i], rts[i]);
            chk(mem[330+i] == e, "R7 shift/rotate result", 32'(mem[330+i]), 32'(e));
        end
    endtask

    task automatic t_halt();
        int cyc;
        bit quiet = 1'b1;
        logic [AW-1:0] p;
        clear_mem();
        mem[80] = 18'h0ABCD;
        mem[0] = enc(1, 0, 0, 80);
        mem[1] = enc(2, 0, 0, 320);
        mem[2] = enc(0, 0, 0, 0);
        run_prog(cyc);
        p = pc_o;
        chk(p == 11'd2, "R8 pc at halt word", 32'(p), 2);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_rd_o || mem_wr_o || !halted_o || pc_o != p) quiet = 1'b0;
        end
        chk(quiet, "R8 halted core quiet", 32'(quiet), 1);
        chk(mem[320] == 18'h0ABCD, "R3 store before halt", 32'(mem[320]), 32'h0ABCD);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_arith();
        t_indirect();
        t_skips();
        t_isz();
        t_shift();
        t_halt();
        chk(rdwr_viol == 0, "R9 no read and write together", 32'(rdwr_viol), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule